// File: doc/BRIEF.md
# Tagged-Token Operand Pairing Unit

This block sits in front of instruction fetch in a tagged-token dataflow engine. Each arriving token names a dynamic instance of an instruction: a context identifier and an instruction address. It also carries a port (left or right operand) and a data word. The unit searches a small associative store of waiting operands for the partner of the arriving token. When it finds the partner, it sends both operands on, already placed on their proper sides, and frees the entry. When no partner is waiting, it parks the token and its output slot stays empty (a bubble) for that cycle.

The lookup key is the context and the address together. Many live instances of one static instruction can therefore wait side by side without colliding. Tokens that feed one-input operators are flagged and go straight through without touching the store. When the store is full and the arriving token can neither complete a pair nor bypass, the unit lowers its ready signal. A second token for an occupied key and an already occupied port is a protocol violation: the unit reports it with a one-cycle error pulse and drops that token.

Top module: `token_pair_matcher`

## Requirements
- R1: After reset `out_valid` and `err_dup` are 0, the store is empty and `in_ready` is 1 for any token.
- R2: A token matches a waiting token only when both context and address are equal. Tokens that differ in context alone never pair.
- R3: When a token is accepted and completes a pair, `out_valid` is 1 in the next cycle, carrying that context and address, and the waiting entry is freed.
- R4: Port encoding is 0 = left and 1 = right. `out_left` carries the left operand and `out_right` the right one, whichever of the two arrived first.
- R5: An accepted two-input token with no waiting partner is stored, and `out_valid` is 0 in the next cycle (bubble).
- R6: An accepted token with `in_single` = 1 gives `out_valid` = 1 and `out_single` = 1 in the next cycle, with `out_left` = its data and `out_right` = 0. The store is left unchanged.
- R7: `in_ready` is 0 only when the store is full, no waiting partner exists and `in_single` is 0. Matching and single tokens are accepted while the store is full.
- R8: An accepted token whose key is waiting on the same port raises `err_dup` for one cycle with `out_valid` 0. The token is dropped and the waiting entry keeps its data.
- R9: `DEPTH` distinct instances of the same instruction address, differing in context, can wait at once, and each later pairs with its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Token present |
| in_ready | output | 1 | Token can be taken this cycle |
| in_ctx | input | CTX_W | Context identifier |
| in_addr | input | ADDR_W | Instruction address |
| in_port | input | 1 | 0 = left, 1 = right |
| in_single | input | 1 | Token feeds a one-input operator |
| in_data | input | DATA_W | Operand value |
| out_valid | output | 1 | Pair or bypass token present |
| out_single | output | 1 | Output is a bypassed single operand |
| out_ctx | output | CTX_W | Context of the output |
| out_addr | output | ADDR_W | Instruction address of the output |
| out_left | output | DATA_W | Left operand |
| out_right | output | DATA_W | Right operand (0 on bypass) |
| err_dup | output | 1 | Same-port duplicate seen |

## Verification
The assertions assume that `in_valid` is 0 while reset is applied and that the producer honours `in_ready`. They also assume that the store never holds two entries with one key. That last condition holds only if inserts happen solely on a miss. The bench drives each token at a falling edge and drops `in_valid` at the next falling edge. It probes the stalled case by lowering `in_valid` before any rising edge can accept the token, and it sends a duplicate only as a deliberate, isolated protocol error. Keys and data are derived arithmetically from loop indices, so every expected pairing is computed directly.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    typedef enum logic {
        PORT_L = 1'b0,
        PORT_R = 1'b1
    } port_e;
endpackage

// File: rtl/tpm_wait_store.sv
module tpm_wait_store #(
    parameter int CTX_W  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTX_W-1:0]  look_ctx,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              hit_port,
    output logic [DATA_W-1:0] hit_data,
    output logic              full,
    output logic [IDX_W-1:0]  free_idx,
    input  logic              ins_en,
    input  logic [IDX_W-1:0]  ins_idx,
    input  logic              ins_port,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);
    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][CTX_W-1:0]  ctx;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0]             port;
        logic [DEPTH-1:0][DATA_W-1:0] data;
    } store_t;

    store_t st_d, st_q;
    logic [DEPTH-1:0] match_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match_vec[g] = st_q.vld[g] && (st_q.ctx[g] == look_ctx)
                              && (st_q.addr[g] == look_addr);
    end

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        full     = &st_q.vld;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!st_q.vld[i]) free_idx = IDX_W'(i);
        end
        hit_port = st_q.port[hit_idx];
        hit_data = st_q.data[hit_idx];

        st_d = st_q;
        if (clr_en) st_d.vld[clr_idx] = 1'b0;
        if (ins_en) begin
            st_d.vld[ins_idx]  = 1'b1;
            st_d.ctx[ins_idx]  = look_ctx;
            st_d.addr[ins_idx] = look_addr;
            st_d.port[ins_idx] = ins_port;
            st_d.data[ins_idx] = ins_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_DOUBLE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !hit); // R2
    AST_INSERT_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !full); // R7
    AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !st_q.vld[$past(clr_idx)]); // R3
    AST_INSERT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> st_q.vld[$past(ins_idx)]); // R5
endmodule

// File: rtl/token_pair_matcher.sv
module token_pair_matcher #(
    parameter int CTX_W  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CTX_W-1:0]  in_ctx,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_port,
    input  logic              in_single,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_single,
    output logic [CTX_W-1:0]  out_ctx,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              err_dup
);
    import tpm_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              single;
        logic              err;
        logic [CTX_W-1:0]  ctx;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] left;
        logic [DATA_W-1:0] right;
    } out_t;

    out_t o_d, o_q;

    logic              hit, hit_port, full;
    logic [IDX_W-1:0]  hit_idx, free_idx;
    logic [DATA_W-1:0] hit_data;
    logic              ins_en, clr_en, take;

    tpm_wait_store #(
        .CTX_W(CTX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .look_ctx(in_ctx), .look_addr(in_addr),
        .hit(hit), .hit_idx(hit_idx), .hit_port(hit_port), .hit_data(hit_data),
        .full(full), .free_idx(free_idx),
        .ins_en(ins_en), .ins_idx(free_idx), .ins_port(in_port), .ins_data(in_data),
        .clr_en(clr_en), .clr_idx(hit_idx)
    );

    always_comb begin
        in_ready = in_single || hit || !full;
        take     = in_valid && in_ready;
        ins_en   = 1'b0;
        clr_en   = 1'b0;
        o_d      = '0;
        o_d.ctx  = o_q.ctx;
        o_d.addr = o_q.addr;
        if (take) begin
            o_d.ctx  = in_ctx;
            o_d.addr = in_addr;
            if (in_single) begin
                o_d.valid  = 1'b1;
                o_d.single = 1'b1;
                o_d.left   = in_data;
            end else if (hit) begin
                if (hit_port != in_port) begin
                    o_d.valid = 1'b1;
                    clr_en    = 1'b1;
                    if (port_e'(in_port) == PORT_L) begin
                        o_d.left  = in_data;
                        o_d.right = hit_data;
                    end else begin
                        o_d.left  = hit_data;
                        o_d.right = in_data;
                    end
                end else begin
                    o_d.err = 1'b1;
                end
            end else begin
                ins_en = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid  = o_q.valid;
    assign out_single = o_q.single;
    assign out_ctx    = o_q.ctx;
    assign out_addr   = o_q.addr;
    assign out_left   = o_q.left;
    assign out_right  = o_q.right;
    assign err_dup    = o_q.err;

    AST_OUT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready)); // R3
    AST_ERR_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        err_dup |-> !out_valid); // R8
    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |-> full); // R7
    AST_SINGLE_KEEPS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_single) |-> (!ins_en && !clr_en)); // R6
endmodule

// File: tb/token_pair_matcher_tb.sv
module token_pair_matcher_tb;
    localparam int CTX_W = 3, ADDR_W = 4, DATA_W = 8, DEPTH = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_port = 1'b0, in_single = 1'b0;
    logic [CTX_W-1:0] in_ctx = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_ready, out_valid, out_single, err_dup;
    logic [CTX_W-1:0] out_ctx;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_left, out_right;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    token_pair_matcher #(.CTX_W(CTX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ctx(in_ctx), .in_addr(in_addr), .in_port(in_port), .in_single(in_single),
        .in_data(in_data), .out_valid(out_valid), .out_single(out_single),
        .out_ctx(out_ctx), .out_addr(out_addr), .out_left(out_left),
        .out_right(out_right), .err_dup(err_dup)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, accept at the rising edge, sample at the next falling edge.
    task automatic send(input int c, input int a, input int p, input int s, input int d);
        in_valid = 1'b1; in_ctx = CTX_W'(c); in_addr = ADDR_W'(a);
        in_port = p[0]; in_single = s[0]; in_data = DATA_W'(d);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic probe_ready(input int c, input int a, input int s, input string req, input int exp);
        in_valid = 1'b1; in_ctx = CTX_W'(c); in_addr = ADDR_W'(a);
        in_port = 1'b0; in_single = s[0]; in_data = '0;
        #1;
        chk(req, int'(in_ready), exp);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_pair(input string req, input int c, input int a, input int l, input int r);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " ctx"}, int'(out_ctx), c);
        chk({req, " addr"}, int'(out_addr), a);
        chk({req, " left"}, int'(out_left), l);
        chk({req, " right"}, int'(out_right), r);
        chk({req, " single"}, int'(out_single), 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 err_dup", int'(err_dup), 0);
        probe_ready(0, 0, 0, "R1 ready", 1);

        // R9, R2, R5: same address, distinct contexts, all left operands
        for (int i = 0; i < DEPTH; i++) begin
            send(i, 5, 0, 0, i * 17 + 1);
            chk("R5 bubble", int'(out_valid), 0);
        end
        // R7: full and unmatched -> stall
        probe_ready(DEPTH, 5, 0, "R7 full stall", 0);
        probe_ready(0, 6, 0, "R7 full stall other addr", 0);
        // R7: matching key still ready while full
        probe_ready(2, 5, 0, "R7 hit ready", 1);
        // R6, R7: single bypass while full
        send(7, 9, 0, 1, 200);
        chk("R6 valid", int'(out_valid), 1);
        chk("R6 single", int'(out_single), 1);
        chk("R6 left", int'(out_left), 200);
        chk("R6 right", int'(out_right), 0);
        chk("R6 ctx", int'(out_ctx), 7);
        // R8: same-port duplicate
        send(0, 5, 0, 0, 99);
        chk("R8 err", int'(err_dup), 1);
        chk("R8 no out", int'(out_valid), 0);
        @(negedge clk);
        chk("R8 err pulse", int'(err_dup), 0);
        // R3, R4, R9, R8: right partners in reverse order
        for (int i = DEPTH - 1; i >= 0; i--) begin
            send(i, 5, 1, 0, i * 3 + 100);
            chk_pair("R3 R4 R9", i, 5, i * 17 + 1, i * 3 + 100);
        end
        // R3: entries freed, store empty again
        probe_ready(6, 2, 0, "R3 freed ready", 1);

        // R4, R2: right-first arrivals over a key sweep, ctx-only differences
        for (int a = 0; a < 4; a++) begin
            for (int c = 0; c < 2; c++) begin
                send(c, a, 1, 0, a * 20 + c * 7 + 3);
                chk("R5 bubble sweep", int'(out_valid), 0);
            end
            for (int c = 1; c >= 0; c--) begin
                send(c, a, 0, 0, a * 11 + c + 150);
                chk_pair("R4 R2 sweep", c, a, a * 11 + c + 150, a * 20 + c * 7 + 3);
            end
        end
        @(negedge clk);
        chk("R5 idle", int'(out_valid), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule